// File: doc/BRIEF.md
# Anti-Replay Migration Counter Guard

This block decides whether a saved context record may be brought back into use. It keeps one root migration counter and a small table of context slots. Each slot holds a valid bit and the counter of the record that is resident there. A record that is presented for loading is accepted only if its slot is resident and both the presented counter and the stored counter equal the root counter. A copy of a record made before a later migration carries an old counter, so it is refused.

When a migration is committed, the root counter steps up by one and the migrated context's slot is freed. The counters of every other resident slot are then stepped up once each, so they keep matching the root. This catch-up is done as a sweep of one slot per clock cycle. While the sweep runs, a busy flag is high and new requests are dropped.

An import fills an empty slot and stamps it with the current root value. The root counter never wraps. When it reaches its largest value, an error flag goes high and further migrations are refused.

Top module: `mcg_guard`

## Requirements
- R1: After reset the root counter is 0, every slot is empty, and grant, deny, busy and the saturation flag are all 0.
- R2: A load request with slot index and counter gets exactly one of grant or deny, in the cycle after it is sampled. It is granted only when the slot is resident and both the presented counter and the stored slot counter equal the root counter. A load changes no state.
- R3: The root counter only counts up. It rises by exactly 1 for each committed migration and is unchanged by every other request.
- R4: A committed migration raises the counter of every other resident slot by exactly 1. Once the sweep ends, a load of such a slot presenting the new root value is granted, and a load presenting the old value is denied.
- R5: An import to an empty slot is granted and stamps that slot with the current root value. An import to a resident slot is denied and leaves the slot unchanged.
- R6: A committed migration empties the migrated slot, so a later load of that slot is denied.
- R7: A migrate request passes the same counter check as a load before it commits. On a mismatch it is denied and neither the root nor any slot changes.
- R8: After a commit, busy is high for exactly NUM_SLOTS cycles. Requests sampled while busy is high get no response and change no state.
- R9: When several request strobes are high in one cycle, only one is served, in the order migrate, then import, then load. The others are dropped.
- R10: When the root counter holds its largest value, the saturation flag is high and stays high. A migrate request is then denied and the root counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside |
| chk_req | input | 1 | Load-check strobe |
| imp_req | input | 1 | Import strobe |
| mig_req | input | 1 | Migrate-commit strobe |
| req_slot | input | IDX_W | Context slot index for the request |
| req_cnt | input | CNT_W | Migration counter carried by the presented record |
| grant | output | 1 | Request accepted (one-cycle pulse) |
| deny | output | 1 | Request refused (one-cycle pulse) |
| busy | output | 1 | Counter catch-up sweep in progress |
| root_cnt | output | CNT_W | Current root counter; this is the stamp value for imports |
| root_sat | output | 1 | Root counter has reached its largest value |

## Verification
Two situations are hard to reach from the ports. The first is a request that arrives while the sweep is running. The bench strobes an import in the very first busy cycle after a grant. It then shows, with a later load, that the slot stayed empty.

The second is root saturation. The bench builds the guard with a 4-bit counter and repeats import-then-migrate on one slot until the root reaches 15. It then confirms that a migrate is refused, while slots that were kept resident across every sweep still load with the final root value.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

  typedef enum logic [1:0] {
    OP_IDLE    = 2'd0,
    OP_LOAD    = 2'd1,
    OP_IMPORT  = 2'd2,
    OP_MIGRATE = 2'd3
  } op_e;

  // fixed service order when strobes coincide: migrate, import, load
  function automatic op_e pick_op(input logic mig, input logic imp, input logic load);
    op_e sel;
    if (mig)       sel = OP_MIGRATE;
    else if (imp)  sel = OP_IMPORT;
    else if (load) sel = OP_LOAD;
    else           sel = OP_IDLE;
    return sel;
  endfunction

endpackage

// File: rtl/mcg_root_ctr.sv
module mcg_root_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sat_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign sat_o  = (cnt_q == CNT_MAX);
  assign cnt_en = inc_en && !sat_o;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_ROOT_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R3

  AST_ROOT_SAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    sat_o |=> sat_o); // R10

endmodule

// File: rtl/mcg_slot_table.sv
module mcg_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_cnt,
  input  logic             stamp_en,
  input  logic [IDX_W-1:0] stamp_idx,
  input  logic [CNT_W-1:0] stamp_val,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             bump_en,
  input  logic [IDX_W-1:0] bump_idx
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_SLOTS-1:0] vld_w;
  logic [CNT_W-1:0]     cnt_w [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic             v_q, v_d;
    logic [CNT_W-1:0] c_q, c_d;
    logic             hit_stamp, hit_clr, hit_bump, slot_en;

    assign hit_stamp = stamp_en && (stamp_idx == IDX_W'(s));
    assign hit_clr   = clr_en   && (clr_idx   == IDX_W'(s));
    assign hit_bump  = bump_en  && (bump_idx  == IDX_W'(s));
    assign slot_en   = hit_stamp || hit_clr || hit_bump;

    always_comb begin
      v_d = v_q;
      c_d = c_q;
      if (hit_clr) v_d = 1'b0;
      if (hit_stamp) begin
        v_d = 1'b1;
        c_d = stamp_val;
      end
      if (hit_bump && v_q && (c_q != CNT_MAX)) c_d = c_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else if (slot_en) begin
        v_q <= v_d;
        c_q <= c_d;
      end
    end

    assign vld_w[s] = v_q;
    assign cnt_w[s] = c_q;
  end

  always_comb begin
    rd_valid = 1'b0;
    rd_cnt   = '0;
    if (int'(rd_idx) < NUM_SLOTS) begin
      rd_valid = vld_w[rd_idx];
      rd_cnt   = cnt_w[rd_idx];
    end
  end

  // a sweep bump and an import stamp never meet in one cycle
  AST_NO_STAMP_DURING_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
    !(stamp_en && bump_en)); // R4

endmodule

// File: rtl/mcg_sweep.sv
module mcg_sweep #(
  parameter int NUM_SLOTS = 8,
  parameter int IDX_W     = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLOTS - 1);

  logic             act_q, act_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             step_en;

  assign step_en = start || act_q;

  always_comb begin
    act_d = act_q;
    idx_d = idx_q;
    if (start) begin
      act_d = 1'b1;
      idx_d = '0;
    end else if (act_q) begin
      if (idx_q == LAST_IDX) act_d = 1'b0;
      else                   idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      idx_q <= '0;
    end else if (step_en) begin
      act_q <= act_d;
      idx_q <= idx_d;
    end
  end

  assign active_o = act_q;
  assign idx_o    = idx_q;

  AST_SWEEP_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> !start); // R8

  AST_SWEEP_VISITS_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && $past(act_q)) |-> (idx_q == IDX_W'($past(idx_q) + 1'b1))); // R4

endmodule

// File: rtl/mcg_guard.sv
module mcg_guard #(
  parameter int NUM_SLOTS = 8,
  parameter int CNT_W     = 16,
  localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_req,
  input  logic             imp_req,
  input  logic             mig_req,
  input  logic [IDX_W-1:0] req_slot,
  input  logic [CNT_W-1:0] req_cnt,
  output logic             grant,
  output logic             deny,
  output logic             busy,
  output logic [CNT_W-1:0] root_cnt,
  output logic             root_sat
);

  import mcg_pkg::*;

  // asynchronous assertion, synchronous release
  logic [1:0] rs_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  logic             sweep_act;
  logic [IDX_W-1:0] sweep_idx;
  logic             sweep_start;
  logic             root_inc;
  logic [CNT_W-1:0] root_q;
  logic             sat;
  logic             tbl_valid;
  logic [CNT_W-1:0] tbl_cnt;
  logic             stamp_en;
  logic             clr_en;
  logic             slot_in_range;
  logic             cnt_match;
  op_e              op;
  logic             grant_d, deny_d, grant_q, deny_q, resp_en;

  mcg_root_ctr #(.CNT_W(CNT_W)) u_root (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .inc_en (root_inc),
    .cnt_o  (root_q),
    .sat_o  (sat)
  );

  mcg_slot_table #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_table (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .rd_idx    (req_slot),
    .rd_valid  (tbl_valid),
    .rd_cnt    (tbl_cnt),
    .stamp_en  (stamp_en),
    .stamp_idx (req_slot),
    .stamp_val (root_q),
    .clr_en    (clr_en),
    .clr_idx   (req_slot),
    .bump_en   (sweep_act),
    .bump_idx  (sweep_idx)
  );

  mcg_sweep #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_sweep (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .start    (sweep_start),
    .active_o (sweep_act),
    .idx_o    (sweep_idx)
  );

  assign op            = sweep_act ? OP_IDLE : pick_op(mig_req, imp_req, chk_req);
  assign slot_in_range = (int'(req_slot) < NUM_SLOTS);
  assign cnt_match     = tbl_valid && (tbl_cnt == root_q) && (req_cnt == root_q);

  always_comb begin
    grant_d     = 1'b0;
    deny_d      = 1'b0;
    stamp_en    = 1'b0;
    clr_en      = 1'b0;
    root_inc    = 1'b0;
    sweep_start = 1'b0;
    unique case (op)
      OP_LOAD: begin
        grant_d = cnt_match;
        deny_d  = !cnt_match;
      end
      OP_IMPORT: begin
        if (slot_in_range && !tbl_valid) begin
          grant_d  = 1'b1;
          stamp_en = 1'b1;
        end else begin
          deny_d = 1'b1;
        end
      end
      OP_MIGRATE: begin
        if (cnt_match && !sat) begin
          grant_d     = 1'b1;
          clr_en      = 1'b1;
          root_inc    = 1'b1;
          sweep_start = 1'b1;
        end else begin
          deny_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  assign resp_en = grant_d || deny_d || grant_q || deny_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
    end else if (resp_en) begin
      grant_q <= grant_d;
      deny_q  <= deny_d;
    end
  end

  assign grant    = grant_q;
  assign deny     = deny_q;
  assign busy     = sweep_act;
  assign root_cnt = root_q;
  assign root_sat = sat;

  AST_SINGLE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_core_n)
    !(grant_q && deny_q)); // R2

  AST_BUSY_MUTES_REQUESTS: assert property (@(posedge clk) disable iff (!rst_core_n)
    sweep_act |=> !(grant_q || deny_q)); // R8

  AST_RESIDENT_MATCHES_ROOT: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!sweep_act && tbl_valid) |-> (tbl_cnt == root_q)); // R4

  AST_NO_COMMIT_SATURATED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (sat && !sweep_act && mig_req) |=> (deny_q && $stable(root_q))); // R10

endmodule

// File: tb/mcg_guard_test.sv
module mcg_guard_test;

  localparam int N   = 8;
  localparam int CW  = 4;
  localparam int IW  = 3;
  localparam int MAXV = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chk_req, imp_req, mig_req;
  logic [IW-1:0] req_slot;
  logic [CW-1:0] req_cnt;
  logic          grant, deny, busy, root_sat;
  logic [CW-1:0] root_cnt;

  always #10 clk = ~clk;

  mcg_guard #(.NUM_SLOTS(N), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .imp_req(imp_req), .mig_req(mig_req),
    .req_slot(req_slot), .req_cnt(req_cnt), .grant(grant), .deny(deny), .busy(busy),
    .root_cnt(root_cnt), .root_sat(root_sat)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard queue: expected grant (1) or deny (0)
  bit    exp_q[$];
  string tag_q[$];

  // bench model
  int root_m;
  bit vld_m[N];

  task automatic check_val(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: pops and compares every response the design produces
  always @(negedge clk) begin
    if (rst_n && !done && (grant || deny)) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 unexpected response actual grant=%0b deny=%0b expected none", grant, deny);
      end else begin
        bit    e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (grant !== e || deny !== !e) begin
          errors++;
          $display("FAIL %s actual grant=%0b deny=%0b expected grant=%0b deny=%0b",
                   t, grant, deny, e, !e);
        end
      end
    end
  end

  // driver: updates the model, pushes the expected outcome, strobes one cycle
  task automatic issue(input bit c, input bit i, input bit m, input int slot,
                       input int cn, input bit quiet, input string tag);
    bit ok;
    if (!quiet) begin
      if (m) begin
        ok = vld_m[slot] && (cn == root_m) && (root_m != MAXV);
        if (ok) begin
          root_m++;
          vld_m[slot] = 0;
        end
      end else if (i) begin
        ok = !vld_m[slot];
        if (ok) vld_m[slot] = 1;
      end else begin
        ok = vld_m[slot] && (cn == root_m);
      end
      exp_q.push_back(ok);
      tag_q.push_back(tag);
    end
    chk_req  = c;
    imp_req  = i;
    mig_req  = m;
    req_slot = IW'(slot);
    req_cnt  = CW'(cn);
    @(negedge clk);
    chk_req = 0; imp_req = 0; mig_req = 0;
    #1;
    if (exp_q.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL %s actual=no response expected=one response", tag_q[0]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
    end
  endtask

  task automatic wait_sweep(output int n);
    n = 0;
    while (busy && n < 100) begin
      n++;
      @(negedge clk);
      #1;
    end
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 0; chk_req = 0; imp_req = 0; mig_req = 0; req_slot = '0; req_cnt = '0;
    root_m = 0;
    foreach (vld_m[k]) vld_m[k] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;

    // R1 reset state
    check_val(grant, 0, "R1 grant");
    check_val(deny, 0, "R1 deny");
    check_val(busy, 0, "R1 busy");
    check_val(root_cnt, 0, "R1 root");
    check_val(root_sat, 0, "R1 sat");

    // R2 load of an empty slot
    issue(1, 0, 0, 4, 0, 0, "R2 load empty");
    // R5 import then duplicate import
    issue(0, 1, 0, 2, 0, 0, "R5 import slot2");
    issue(0, 1, 0, 2, 0, 0, "R5 import occupied");
    // R2 good and bad counters
    issue(1, 0, 0, 2, 0, 0, "R2 load match");
    issue(1, 0, 0, 2, 3, 0, "R2 load mismatch");
    check_val(root_cnt, 0, "R3 root unchanged by loads");

    issue(0, 1, 0, 3, 0, 0, "R5 import slot3");
    issue(0, 1, 0, 5, 0, 0, "R5 import slot5");

    // R7 migrate with wrong counter
    issue(0, 0, 1, 3, 1, 0, "R7 migrate mismatch");
    check_val(root_cnt, 0, "R7 root unchanged");
    check_val(busy, 0, "R7 no sweep");

    // R3 R8 committed migrate, sweep length
    issue(0, 0, 1, 3, 0, 0, "R3 migrate commit");
    check_val(root_cnt, 1, "R3 root step");
    wait_sweep(n);
    check_val(n, N, "R8 busy length");

    // R6 migrated slot gone
    issue(1, 0, 0, 3, 1, 0, "R6 load migrated slot");
    // R4 others caught up, stale copy refused
    issue(1, 0, 0, 2, 1, 0, "R4 slot2 new value");
    issue(1, 0, 0, 5, 1, 0, "R4 slot5 new value");
    issue(1, 0, 0, 2, 0, 0, "R4 slot2 stale value");

    // R5 import stamps current root
    issue(0, 1, 0, 6, 0, 0, "R5 import slot6");
    issue(1, 0, 0, 6, 1, 0, "R5 slot6 stamped root");

    // R8 request during busy is dropped
    issue(0, 0, 1, 6, 1, 0, "R8 migrate slot6");
    check_val(busy, 1, "R8 busy after commit");
    issue(0, 1, 0, 7, 0, 1, "R8 import while busy");
    wait_sweep(n);
    issue(1, 0, 0, 7, root_m, 0, "R8 slot7 still empty");
    check_val(root_cnt, 2, "R3 root after two commits");

    // R9 priority: import beats load, migrate beats load
    issue(1, 1, 0, 7, 2, 0, "R9 import over load");
    issue(1, 0, 0, 7, 2, 0, "R9 slot7 imported");
    issue(1, 0, 1, 7, 2, 0, "R9 migrate over load");
    wait_sweep(n);
    issue(1, 0, 0, 7, 3, 0, "R9 slot7 migrated");

    // R10 drive the root to saturation
    while (root_m < MAXV) begin
      issue(0, 1, 0, 0, 0, 0, "R5 import slot0");
      issue(0, 0, 1, 0, root_m, 0, "R3 migrate slot0");
      wait_sweep(n);
    end
    check_val(root_cnt, MAXV, "R10 root at max");
    check_val(root_sat, 1, "R10 sat flag");
    issue(1, 0, 0, 2, MAXV, 0, "R4 slot2 tracked to max");
    issue(0, 0, 1, 2, MAXV, 0, "R10 migrate refused");
    check_val(busy, 0, "R10 no sweep");
    check_val(root_cnt, MAXV, "R10 root held");
    check_val(root_sat, 1, "R10 sat stays");
    issue(1, 0, 0, 2, MAXV, 0, "R10 slot2 still resident");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule